// File: doc/BRIEF.md
# Display RAM XY Address Auto-Incrementer

This block keeps the column-word (X) and row (Y) address counters that point into the display memory of a small LCD controller. Each display-data read or write is reported to it by a one-cycle access strobe. On every such strobe, one of the two counters advances. A mode bit chooses which counter moves. The other counter moves only when the stepping counter wraps, and then by exactly one.

The range of X depends on the word length. Eight-bit words give a range of 0..7, or 0..6 when the `REDUCED_COLS` parameter is set. Six-bit words give a range of 0..9. The range of Y follows the display duty setting. Both counters can be loaded directly by the host. A load wins over any increment of the same counter in the same cycle. The mode settings (step axis, word length, duty) are captured in a small register when `cfgWe` is high, and they take effect from the following cycle.

Top module: `xy_addr_incr`

## Requirements
- R1: After reset both addresses read 0, the step axis is Y, the word length is 8 bits and the duty is 1/8 (Y range 0..7).
- R2: With the step-axis bit at 0, each access strobe raises Y by one, and X is unchanged unless Y wraps.
- R3: With the step-axis bit at 1, each access strobe raises X by one, and Y is unchanged unless X wraps.
- R4: With `cfgWord6`=0 (8-bit words), X counts 0..7 and then returns to 0 (0..6 when `REDUCED_COLS`=1).
- R5: With `cfgWord6`=1 (6-bit words), X counts 0..9 and then returns to 0.
- R6: The `cfgDuty` code sets the Y maximum: code 0 gives 7 (1/8 duty), code 1 gives 8 (1/9 duty), and codes 2 and 3 give 9 (1/10 duty). Y returns to 0 after its maximum.
- R7: When X is stepping and wraps to 0, Y rises by one in the same cycle and wraps to 0 if it was at its own maximum.
- R8: When Y is stepping and wraps to 0, X rises by one in the same cycle and wraps to 0 if it was at its own maximum.
- R9: A load of X (`xLoad`) or Y (`yLoad`) sets that counter to the given value on the next edge, overriding any increment or carry into that counter in the same cycle.
- R10: With no access and no load, both addresses hold. A mode write changes neither address, and a strobe in the same cycle as a mode write uses the previous mode.
- R11: An access strobe held high for N cycles gives N increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Capture the mode fields on this edge |
| cfgStepX | input | 1 | Step axis: 0 = Y, 1 = X |
| cfgWord6 | input | 1 | Word length: 0 = 8 bits, 1 = 6 bits |
| cfgDuty | input | 2 | Duty code: 0 = 1/8, 1 = 1/9, 2 or 3 = 1/10 |
| xLoad | input | 1 | Load X from xLoadVal |
| xLoadVal | input | ADDR_W | Value to load into X |
| yLoad | input | 1 | Load Y from yLoadVal |
| yLoadVal | input | ADDR_W | Value to load into Y |
| access | input | 1 | One display-data read or write in this cycle |
| xAddr | output | ADDR_W | Current X address |
| yAddr | output | ADDR_W | Current Y address |

## Verification
The assertions assume that every loaded value lies inside the range set by the current mode. They also assume the mode is never narrowed while a counter sits above the new maximum, because counting outside the range is left undefined. The stimulus only moves to wider ranges (1/8 to 1/10 duty, 8-bit to 6-bit words) and loads only values within the active range, so both counters stay inside their limits throughout. The corner where both counters sit at their maxima and the stepping one wraps is driven on purpose, so that the double wrap is checked.

// File: rtl/xy_addr_pkg.sv
package xy_addr_pkg;
  localparam int unsigned ADDR_W_DEF = 4;

  localparam logic [1:0] DUTY_1_8  = 2'd0;
  localparam logic [1:0] DUTY_1_9  = 2'd1;
  localparam logic [1:0] DUTY_1_10 = 2'd2;

  typedef struct packed {
    logic loadX;
    logic loadY;
    logic stepX;
    logic stepY;
    logic carryIntoX;
    logic carryIntoY;
  } ctlStrobes_t;
endpackage

// File: rtl/xy_addr_ctl.sv
module xy_addr_ctl
  import xy_addr_pkg::*;
#(
  parameter int unsigned ADDR_W       = ADDR_W_DEF,
  parameter bit          REDUCED_COLS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgStepX,
  input  logic              cfgWord6,
  input  logic [1:0]        cfgDuty,
  input  logic              access,
  input  logic              xLoad,
  input  logic              yLoad,
  input  logic              xAtMax,
  input  logic              yAtMax,
  output ctlStrobes_t       strb,
  output logic [ADDR_W-1:0] xMax,
  output logic [ADDR_W-1:0] yMax
);
  localparam logic [ADDR_W-1:0] X_MAX_W8 = REDUCED_COLS ? ADDR_W'(6) : ADDR_W'(7);
  localparam logic [ADDR_W-1:0] X_MAX_W6 = ADDR_W'(9);

  logic       stepSelX;
  logic       word6;
  logic [1:0] duty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepSelX <= 1'b0;
      word6    <= 1'b0;
      duty     <= DUTY_1_8;
    end else if (cfgWe) begin
      stepSelX <= cfgStepX;
      word6    <= cfgWord6;
      duty     <= cfgDuty;
    end
  end

  always_comb begin
    xMax = word6 ? X_MAX_W6 : X_MAX_W8;
    unique case (duty)
      DUTY_1_8: yMax = ADDR_W'(7);
      DUTY_1_9: yMax = ADDR_W'(8);
      default:  yMax = ADDR_W'(9);
    endcase
  end

  always_comb begin
    strb.loadX      = xLoad;
    strb.loadY      = yLoad;
    strb.stepX      = access &  stepSelX;
    strb.stepY      = access & ~stepSelX;
    strb.carryIntoY = access &  stepSelX & xAtMax;
    strb.carryIntoX = access & ~stepSelX & yAtMax;
  end

  // R10: limits move only after a mode write
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> ($stable(xMax) && $stable(yMax)));
endmodule

// File: rtl/xy_axis_cnt.sv
module xy_axis_cnt #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              inc,
  input  logic [ADDR_W-1:0] maxVal,
  output logic [ADDR_W-1:0] cnt,
  output logic              atMax
);
  assign atMax = (cnt == maxVal);

  always_ff @(posedge clk) begin
    if (!rstN)      cnt <= '0;
    else if (load)  cnt <= loadVal;
    else if (inc)   cnt <= atMax ? '0 : cnt + 1'b1;
  end

  // R9: a load takes precedence over an increment
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    load |=> cnt == $past(loadVal));
  // R4/R5/R6: a counter at its limit goes back to zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !load && atMax) |=> cnt == '0);
  // R2/R3: below the limit it moves up by exactly one
  p_step_one_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inc && !load && !atMax) |=> cnt == $past(cnt) + 1'b1);
  // R10: idle counter holds
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/xy_addr_dp.sv
module xy_addr_dp
  import xy_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] xMax,
  input  logic [ADDR_W-1:0] yMax,
  input  logic [ADDR_W-1:0] xLoadVal,
  input  logic [ADDR_W-1:0] yLoadVal,
  output logic [ADDR_W-1:0] xAddr,
  output logic [ADDR_W-1:0] yAddr,
  output logic              xAtMax,
  output logic              yAtMax
);
  logic xInc, yInc;
  assign xInc = strb.stepX | strb.carryIntoX;
  assign yInc = strb.stepY | strb.carryIntoY;

  xy_axis_cnt #(.ADDR_W(ADDR_W)) xCnt_i (
    .clk(clk), .rstN(rstN), .load(strb.loadX), .loadVal(xLoadVal),
    .inc(xInc), .maxVal(xMax), .cnt(xAddr), .atMax(xAtMax));

  xy_axis_cnt #(.ADDR_W(ADDR_W)) yCnt_i (
    .clk(clk), .rstN(rstN), .load(strb.loadY), .loadVal(yLoadVal),
    .inc(yInc), .maxVal(yMax), .cnt(yAddr), .atMax(yAtMax));

  // R7: X wrapping while stepping drags Y along
  p_x_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepX && xAtMax && !strb.loadX && !strb.loadY && !yAtMax)
      |=> (xAddr == '0 && yAddr == $past(yAddr) + 1'b1));
  // R8: Y wrapping while stepping drags X along
  p_y_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepY && yAtMax && !strb.loadX && !strb.loadY && !xAtMax)
      |=> (yAddr == '0 && xAddr == $past(xAddr) + 1'b1));
  // R2: stepping Y without wrap leaves X alone
  p_y_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepY && !yAtMax && !strb.loadX) |=> $stable(xAddr));
  // R3: stepping X without wrap leaves Y alone
  p_x_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepX && !xAtMax && !strb.loadY) |=> $stable(yAddr));
endmodule

// File: rtl/xy_addr_incr.sv
module xy_addr_incr
  import xy_addr_pkg::*;
#(
  parameter int unsigned ADDR_W       = ADDR_W_DEF,
  parameter bit          REDUCED_COLS = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgStepX,
  input  logic              cfgWord6,
  input  logic [1:0]        cfgDuty,
  input  logic              xLoad,
  input  logic [ADDR_W-1:0] xLoadVal,
  input  logic              yLoad,
  input  logic [ADDR_W-1:0] yLoadVal,
  input  logic              access,
  output logic [ADDR_W-1:0] xAddr,
  output logic [ADDR_W-1:0] yAddr
);
  ctlStrobes_t       strb;
  logic [ADDR_W-1:0] xMax, yMax;
  logic              xAtMax, yAtMax;

  xy_addr_ctl #(.ADDR_W(ADDR_W), .REDUCED_COLS(REDUCED_COLS)) ctl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgStepX(cfgStepX),
    .cfgWord6(cfgWord6), .cfgDuty(cfgDuty), .access(access),
    .xLoad(xLoad), .yLoad(yLoad), .xAtMax(xAtMax), .yAtMax(yAtMax),
    .strb(strb), .xMax(xMax), .yMax(yMax));

  xy_addr_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .xMax(xMax), .yMax(yMax),
    .xLoadVal(xLoadVal), .yLoadVal(yLoadVal),
    .xAddr(xAddr), .yAddr(yAddr), .xAtMax(xAtMax), .yAtMax(yAtMax));
endmodule

// File: tb/xy_addr_incr_tb.sv
module xy_addr_incr_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWe, cfgStepX, cfgWord6;
  logic [1:0] cfgDuty;
  logic       xLoad, yLoad, access;
  logic [3:0] xLoadVal, yLoadVal;
  logic [3:0] xAddr, yAddr;

  int total = 0;
  int bad   = 0;
  int mX = 0, mY = 0, mStepX = 0, mWord6 = 0, mDuty = 0;

  always #5 clk = ~clk;

  xy_addr_incr dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgStepX(cfgStepX),
    .cfgWord6(cfgWord6), .cfgDuty(cfgDuty), .xLoad(xLoad),
    .xLoadVal(xLoadVal), .yLoad(yLoad), .yLoadVal(yLoadVal),
    .access(access), .xAddr(xAddr), .yAddr(yAddr));

  function automatic int limX();
    return (mWord6 != 0) ? 9 : 7;
  endfunction

  function automatic int limY();
    if (mDuty == 0) return 7;
    if (mDuty == 1) return 8;
    return 9;
  endfunction

  task automatic check(string req);
    total++;
    if (int'(xAddr) != mX || int'(yAddr) != mY) begin
      bad++;
      $display("FAIL %s: x=%0d y=%0d expected x=%0d y=%0d", req, xAddr, yAddr, mX, mY);
    end
  endtask

  // one clock of stimulus; the model advances behaviourally and is compared after the edge
  task automatic cyc(input bit acc, input bit lx, input int lxv, input bit ly, input int lyv,
                     input bit we, input bit sx, input bit w6, input int du, input string req);
    int nx, ny;
    @(negedge clk);
    access = acc; xLoad = lx; xLoadVal = 4'(lxv); yLoad = ly; yLoadVal = 4'(lyv);
    cfgWe = we; cfgStepX = sx; cfgWord6 = w6; cfgDuty = 2'(du);
    nx = mX; ny = mY;
    if (acc) begin
      if (mStepX != 0) begin
        if (mX == limX()) begin nx = 0; ny = (mY == limY()) ? 0 : mY + 1; end
        else nx = mX + 1;
      end else begin
        if (mY == limY()) begin ny = 0; nx = (mX == limX()) ? 0 : mX + 1; end
        else ny = mY + 1;
      end
    end
    if (lx) nx = lxv;
    if (ly) ny = lyv;
    if (we) begin mStepX = sx; mWord6 = w6; mDuty = du; end
    mX = nx; mY = ny;
    @(posedge clk); #1;
    check(req);
  endtask

  task automatic acc1(string req);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic mode(bit sx, bit w6, int du, string req);
    cyc(0, 0, 0, 0, 0, 1, sx, w6, du, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: x=%0d y=%0d expected finish", xAddr, yAddr);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; access = 0; xLoad = 0; yLoad = 0; xLoadVal = 0; yLoadVal = 0;
    cfgWe = 0; cfgStepX = 0; cfgWord6 = 0; cfgDuty = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 reset");
    // R1/R2/R6/R8: default Y stepping, duty 1/8, two full Y sweeps carrying into X
    for (int i = 0; i < 18; i++) acc1("R2 R6 R8 default step Y");
    // R10: idle cycles hold
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle hold");
    // R10: mode write together with an access uses the old mode for that access
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 1, "R10 mode write with access");
    for (int i = 0; i < 12; i++) acc1("R6 duty 1/9");
    mode(0, 0, 2, "R10 mode write only");
    for (int i = 0; i < 12; i++) acc1("R6 duty 1/10");
    // R8: Y wraps with X at its 8-bit maximum, so both go to 0
    cyc(0, 1, 7, 1, 9, 0, 0, 0, 0, "R9 load both");
    acc1("R8 R4 double wrap");
    // R3/R4/R7: X stepping in 8-bit mode
    mode(1, 0, 2, "R10 switch to X");
    for (int i = 0; i < 20; i++) acc1("R3 R4 R7 step X 8-bit");
    cyc(0, 0, 0, 1, 9, 0, 0, 0, 0, "R9 load Y");
    for (int i = 0; i < 9; i++) acc1("R7 X wrap carries Y wrap");
    // R5: 6-bit words
    mode(1, 1, 2, "R10 switch to 6-bit");
    for (int i = 0; i < 25; i++) acc1("R5 R7 step X 6-bit");
    // R9: loads beat increments and carries
    cyc(1, 1, 3, 0, 0, 0, 0, 0, 0, "R9 X load beats step");
    cyc(0, 1, 9, 1, 9, 0, 0, 0, 0, "R9 load both max");
    cyc(1, 0, 0, 1, 4, 0, 0, 0, 0, "R9 Y load beats carry");
    // R8: Y stepping in 6-bit mode, X at 9 wraps via carry
    mode(0, 1, 3, "R10 step Y duty code 3");
    cyc(0, 1, 9, 1, 8, 0, 0, 0, 0, "R9 load");
    for (int i = 0; i < 14; i++) acc1("R8 R6 R11 held strobe");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule